// File: doc/BRIEF.md
# Comparator-Terminated Pulse Controller for Switch-Mode Supplies

This block generates the gate-drive pulse of a switch-mode power converter. A free-running period counter sets the switching frequency. An analog comparator (or the OR of two comparators) reports when the sensed current or voltage has reached its limit. Software configures the block through two 8-bit control words written over a simple write strobe, and then enables it.

The block has two modes. In PWM mode a pulse starts at every period boundary and ends on the first comparator trip at or after a programmable minimum duty point. It is always ended at a programmable maximum duty point. In skip mode each pulse has a fixed width, and the comparator is consulted once at the start of the period to decide whether that whole pulse is dropped.

Output A always carries the pulse. Output B can carry a second copy of the pulse or an active-high slope-compensation window, or it can be left unused. Each output has its own polarity bit and its own enable flag, which the pad ring uses as a tri-state control. The comparator inputs and the pin multiplexing are outside this block.

Top module: `smps_pulse_ctrl`

## Requirements
- R1: While reset is held and until the module is enabled, `oe_a` and `oe_b` are 0 and `out_a` and `out_b` are 0.
- R2: A write with `wr_addr`=0 loads word 0: bits [1:0] frequency code, [3:2] minimum duty code, [5:4] maximum duty code, [7:6] fixed duty code. A write with `wr_addr`=1 loads word 1: bit 0 enable, bit 1 mode (1 = PWM, 0 = skip), bit 2 input select, bit 3 dual output, bit 4 polarity A, bit 5 polarity B, bit 6 slope compensation. A write takes effect at the clock edge that samples `wr_en`. The pins reflect it one edge later.
- R3: While enabled, the period is 256, 128, 64 or 32 clocks for frequency codes 0, 1, 2 and 3. The period count starts at 0 on the first enabled cycle.
- R4: A word-0 write made while enabled leaves the frequency code unchanged and updates the other three fields.
- R5: In PWM mode the pulse is active from count 0. A comparator trip seen at count c ends the pulse from count c+1 only if c is at least the minimum duty count. The minimum duty count is 0, 1/8, 2/8 or 3/8 of the period for codes 0 to 3.
- R6: In PWM mode the pulse is inactive from the maximum duty count to the end of the period. The maximum duty count is 4/8, 5/8, 6/8 or 8/8 of the period for codes 0 to 3.
- R7: In skip mode a trip present at count 0 suppresses the whole pulse of that period, and trips at other counts have no effect. An unsuppressed pulse is active for counts below 1/8, 2/8, 3/8 or 4/8 of the period for fixed codes 0 to 3.
- R8: With input select 0 the trip signal is `cmp_a` alone, and `cmp_b` is ignored. With input select 1 the trip signal is `cmp_a` OR `cmp_b`.
- R9: With a polarity bit set, the pin is 1 while the pulse is inactive and 0 while it is active. With the bit clear, the pin follows the pulse.
- R10: With dual output set, `out_b` carries the pulse with polarity B. With dual clear and slope set, `out_b` is 1 exactly while the pulse is active and ignores polarity B. With both clear, `out_b` is 0.
- R11: `oe_a` equals the enable bit, and `oe_b` equals enable AND (dual OR slope), both delayed by one edge. When disabled, both pins are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control words |
| wr_addr | input | 1 | Control word select |
| wr_data | input | 8 | Write data |
| cmp_a | input | 1 | First comparator trip, active high |
| cmp_b | input | 1 | Second comparator trip, active high |
| out_a | output | 1 | Pulse output A |
| out_b | output | 1 | Output B: pulse copy or slope window |
| oe_a | output | 1 | Drive enable for output A |
| oe_b | output | 1 | Drive enable for output B |

## Verification
The pulse logic is exercised with several comparator patterns. With no trip at all, only the maximum clamp or the fixed width can end the pulse. A trip placed before the minimum point tells a working minimum clamp apart from an early termination. A trip placed after the minimum point shows whether the pulse ends on the next count. A trip only at count 0 in skip mode, compared with one at count 5, separates whole-pulse suppression from a mid-pulse cut. A trip driven only on the second comparator, with input select toggled, shows whether the input selection is honoured.

// File: rtl/smps_pkg.sv
package smps_pkg;

  // Control word 0: timing fields
  typedef struct packed {
    logic [1:0] fixd;   // fixed duty code (skip mode)
    logic [1:0] maxd;   // maximum duty code (PWM)
    logic [1:0] mind;   // minimum duty code (PWM)
    logic [1:0] freq;   // period select
  } ctl0_t;

  // Control word 1: operating fields
  typedef struct packed {
    logic slope;        // output B as slope window
    logic pol_b;        // output B active low
    logic pol_a;        // output A active low
    logic dual;         // drive output B with the pulse
    logic insel;        // OR both comparators
    logic pwm;          // 1 = PWM, 0 = skip
    logic en;           // module enable
  } ctl1_t;

endpackage

// File: rtl/smps_regs.sv
module smps_regs
  import smps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  output ctl0_t      c0,
  output ctl1_t      c1
);

  ctl0_t c0_q, c0_n;
  ctl1_t c1_q, c1_n;

  always_comb begin
    c0_n = c0_q;
    c1_n = c1_q;
    if (wr_en) begin
      if (!wr_addr) begin
        c0_n = ctl0_t'(wr_data);
        // period select is frozen while running
        if (c1_q.en) c0_n.freq = c0_q.freq;
      end else begin
        c1_n = ctl1_t'(wr_data[6:0]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c0_q <= '0;
      c1_q <= '0;
    end else begin
      c0_q <= c0_n;
      c1_q <= c1_n;
    end
  end

  assign c0 = c0_q;
  assign c1 = c1_q;

  // R4: frequency code cannot move while the module stays enabled
  p_freq_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (c1_q.en && $past(c1_q.en)) |-> $stable(c0_q.freq));

endmodule

// File: rtl/smps_timebase.sv
module smps_timebase #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       freq,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W:0]   period,
  output logic             wrap
);

  localparam int PW = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    period = PW'(1) << (PW'(CNT_W) - PW'(freq));
    wrap   = run && ({1'b0, cnt_q} == period - PW'(1));
    if (!run)      cnt_n = '0;
    else if (wrap) cnt_n = '0;
    else           cnt_n = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign cnt = cnt_q;

  // R3: count stays inside the selected period
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cnt_q} < period));

  // R3: terminal count returns the counter to zero
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));

endmodule

// File: rtl/smps_pulse_core.sv
module smps_pulse_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pwm,
  input  logic             trip,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W:0]   period,
  input  logic             wrap,
  input  logic [1:0]       mind,
  input  logic [1:0]       maxd,
  input  logic [1:0]       fixd,
  output logic             act
);

  localparam int PW = CNT_W + 1;

  logic [PW-1:0] eighth, min_cnt, max_cnt, fix_cnt, cnt_x;
  logic          term_q, term_n;
  logic          skip_q, skip_n;
  logic          start, skip_now;

  always_comb begin
    eighth  = period >> 3;
    min_cnt = PW'(mind) * eighth;
    max_cnt = (maxd == 2'd3) ? period : (PW'(maxd) + PW'(4)) * eighth;
    fix_cnt = (PW'(fixd) + PW'(1)) * eighth;
    cnt_x   = {1'b0, cnt};
    start   = (cnt == '0);
  end

  // pulse-ended flag for PWM, skip flag for skip mode
  always_comb begin
    term_n = term_q;
    skip_n = skip_q;
    if (!run) begin
      term_n = 1'b0;
      skip_n = 1'b0;
    end else begin
      if (wrap)                              term_n = 1'b0;
      else if (pwm && trip && cnt_x >= min_cnt) term_n = 1'b1;
      if (start)                             skip_n = trip;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_q <= 1'b0;
      skip_q <= 1'b0;
    end else begin
      term_q <= term_n;
      skip_q <= skip_n;
    end
  end

  always_comb begin
    skip_now = start ? trip : skip_q;
    if (!run)     act = 1'b0;
    else if (pwm) act = (cnt_x < max_cnt) && !term_q;
    else          act = !skip_now && (cnt_x < fix_cnt);
  end

  // R5: no termination can take effect up to the minimum duty point
  p_min_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pwm && cnt_x <= min_cnt) |-> act);

  // R7: a skipped period stays dark after its first count
  p_skip_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pwm && skip_q && !start) |-> !act);

endmodule

// File: rtl/smps_pulse_ctrl.sv
module smps_pulse_ctrl
  import smps_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  input  logic       cmp_a,
  input  logic       cmp_b,
  output logic       out_a,
  output logic       out_b,
  output logic       oe_a,
  output logic       oe_b
);

  // reset: asserted asynchronously, released through two flops
  logic rst_s1, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1  <= 1'b0;
      rst_i_n <= 1'b0;
    end else begin
      rst_s1  <= 1'b1;
      rst_i_n <= rst_s1;
    end
  end

  ctl0_t            c0;
  ctl1_t            c1;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   period;
  logic             wrap, trip, act;

  smps_regs u_regs (
    .clk(clk), .rst_n(rst_i_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .c0(c0), .c1(c1)
  );

  smps_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_i_n), .run(c1.en), .freq(c0.freq),
    .cnt(cnt), .period(period), .wrap(wrap)
  );

  assign trip = c1.insel ? (cmp_a | cmp_b) : cmp_a;

  smps_pulse_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_i_n), .run(c1.en), .pwm(c1.pwm), .trip(trip),
    .cnt(cnt), .period(period), .wrap(wrap), .mind(c0.mind),
    .maxd(c0.maxd), .fixd(c0.fixd), .act(act)
  );

  // registered pin stage
  logic oa_q, ob_q, ea_q, eb_q;
  logic oa_n, ob_n, ea_n, eb_n;

  always_comb begin
    ea_n = c1.en;
    eb_n = c1.en && (c1.dual || c1.slope);
    oa_n = 1'b0;
    ob_n = 1'b0;
    if (c1.en) begin
      oa_n = act ^ c1.pol_a;
      if (c1.dual)       ob_n = act ^ c1.pol_b;
      else if (c1.slope) ob_n = act;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      oa_q <= 1'b0;
      ob_q <= 1'b0;
      ea_q <= 1'b0;
      eb_q <= 1'b0;
    end else begin
      oa_q <= oa_n;
      ob_q <= ob_n;
      ea_q <= ea_n;
      eb_q <= eb_n;
    end
  end

  assign out_a = oa_q;
  assign out_b = ob_q;
  assign oe_a  = ea_q;
  assign oe_b  = eb_q;

  // R11: output B is never enabled without output A
  p_oe_pair_r11: assert property (@(posedge clk) disable iff (!rst_i_n)
    oe_b |-> oe_a);

  // R1: pins are low whenever the module is not driving
  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_i_n)
    !oe_a |-> (!out_a && !out_b));

endmodule

// File: tb/sim_smps_pulse_ctrl.sv
`timescale 1ns/100ps
module sim_smps_pulse_ctrl;

  localparam int CW = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, wr_addr;
  logic [7:0] wr_data;
  logic       cmp_a, cmp_b;
  logic       out_a, out_b, oe_a, oe_b;

  always #2.5 clk = ~clk;

  smps_pulse_ctrl #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .out_a(out_a), .out_b(out_b), .oe_a(oe_a), .oe_b(oe_b)
  );

  int    n_run = 0, n_fail = 0;
  string cur_req = "R1";
  bit    live = 1'b0;
  int    trip_a_at = -1, trip_b_at = -1;

  task automatic chk(input bit ok, input string req, input string what);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s", req, what);
    end
  endtask

  // behavioural reference
  int   m_cnt, m_term, m_skip;
  bit [7:0] m_c0, m_c1;
  bit   e_oa, e_ob, e_ea, e_eb;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_term = 0; m_skip = 0; m_c0 = 0; m_c1 = 0;
      e_oa = 0; e_ob = 0; e_ea = 0; e_eb = 0;
    end else begin
      int p, e8, mn, mx, fx;
      bit trip, act, en, pwm, sk;
      en  = m_c1[0];
      pwm = m_c1[1];
      p   = 256 >> m_c0[1:0];
      e8  = p / 8;
      mn  = m_c0[3:2] * e8;
      mx  = (m_c0[5:4] == 3) ? p : (4 + m_c0[5:4]) * e8;
      fx  = (m_c0[7:6] + 1) * e8;
      trip = m_c1[2] ? (cmp_a | cmp_b) : cmp_a;
      act = 0;
      if (en) begin
        if (pwm) act = (m_cnt < mx) && (m_term == 0);
        else begin
          sk  = (m_cnt == 0) ? trip : (m_skip != 0);
          act = !sk && (m_cnt < fx);
        end
      end
      e_ea = en;
      e_eb = en && (m_c1[3] || m_c1[6]);
      e_oa = en ? (act ^ m_c1[4]) : 1'b0;
      e_ob = !en ? 1'b0 : m_c1[3] ? (act ^ m_c1[5]) : m_c1[6] ? act : 1'b0;
      if (!en) begin
        m_cnt = 0; m_term = 0; m_skip = 0;
      end else begin
        if (m_cnt == 0) m_skip = trip;
        if (m_cnt == p - 1) begin
          m_cnt = 0; m_term = 0;
        end else begin
          if (pwm && trip && m_cnt >= mn) m_term = 1;
          m_cnt = m_cnt + 1;
        end
      end
      if (wr_en) begin
        if (!wr_addr) m_c0 = en ? {wr_data[7:2], m_c0[1:0]} : wr_data;
        else          m_c1 = {1'b0, wr_data[6:0]};
      end
    end
  end

  // compare every cycle, then drive comparators for the next edge
  always @(negedge clk) begin
    if (live)
      chk({out_a, out_b, oe_a, oe_b} == {e_oa, e_ob, e_ea, e_eb}, cur_req,
          $sformatf("cnt=%0d got a=%b b=%b oea=%b oeb=%b exp %b %b %b %b",
                    m_cnt, out_a, out_b, oe_a, oe_b, e_oa, e_ob, e_ea, e_eb));
    cmp_a = (trip_a_at >= 0) && (m_cnt == trip_a_at);
    cmp_b = (trip_b_at >= 0) && (m_cnt == trip_b_at);
  end

  task automatic wr(input bit a, input bit [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic bit [7:0] w0(int f, int mn, int mx, int fx);
    return {fx[1:0], mx[1:0], mn[1:0], f[1:0]};
  endfunction

  // en | pwm<<1 | insel<<2 | dual<<3 | pola<<4 | polb<<5 | slope<<6
  function automatic bit [7:0] w1(bit en, bit pwm, bit insel, bit dual,
                                  bit pa, bit pb, bit sl);
    return {1'b0, sl, pb, pa, dual, insel, pwm, en};
  endfunction

  task automatic cfg(input bit [7:0] c0, input bit [7:0] c1);
    wr(1'b1, 8'h00);
    wr(1'b0, c0);
    wr(1'b1, c1);
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #750000;
    n_fail++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0;
    cmp_a = 1'b0; cmp_b = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state at the pins
    chk({out_a, out_b, oe_a, oe_b} == 4'b0000, "R1",
        $sformatf("in reset got %b%b%b%b exp 0000", out_a, out_b, oe_a, oe_b));
    rst_n = 1'b1;
    run(5);
    chk({out_a, out_b, oe_a, oe_b} == 4'b0000, "R1",
        $sformatf("after reset got %b%b%b%b exp 0000", out_a, out_b, oe_a, oe_b));
    live = 1'b1;

    cur_req = "R2";
    wr(1'b0, w0(3, 0, 0, 0));
    wr(1'b1, w1(1, 1, 0, 0, 0, 0, 0));
    run(1);
    chk(oe_a == 1'b1, "R2", $sformatf("oe_a=%b exp 1 after enable", oe_a));
    run(100);

    cur_req = "R3";
    cfg(w0(0, 0, 0, 0), w1(1, 1, 0, 0, 0, 0, 0));
    run(600);
    cfg(w0(2, 0, 0, 0), w1(1, 1, 0, 0, 0, 0, 0));
    run(200);

    cur_req = "R4";
    wr(1'b0, w0(3, 0, 1, 0));   // frequency change must be ignored
    run(300);

    cur_req = "R5";
    trip_a_at = 10;             // before minimum point: ignored
    cfg(w0(2, 2, 3, 0), w1(1, 1, 0, 0, 0, 0, 0));
    run(200);
    trip_a_at = 20;             // after minimum point: ends pulse
    run(200);
    trip_a_at = 0;
    cfg(w0(2, 0, 3, 0), w1(1, 1, 0, 0, 0, 0, 0));
    run(150);

    cur_req = "R6";
    trip_a_at = -1;
    for (int k = 0; k < 4; k++) begin
      cfg(w0(2, 1, k, 0), w1(1, 1, 0, 0, 0, 0, 0));
      run(150);
    end

    cur_req = "R7";
    cfg(w0(2, 0, 0, 1), w1(1, 0, 0, 0, 0, 0, 0));
    run(150);
    trip_a_at = 0;
    run(150);
    trip_a_at = 5;
    run(150);
    trip_a_at = -1;
    cfg(w0(3, 0, 0, 3), w1(1, 0, 0, 0, 0, 0, 0));
    run(100);

    cur_req = "R8";
    trip_b_at = 8;
    cfg(w0(2, 0, 3, 0), w1(1, 1, 0, 0, 0, 0, 0));
    run(150);
    cfg(w0(2, 0, 3, 0), w1(1, 1, 1, 0, 0, 0, 0));
    run(150);
    trip_b_at = -1;

    cur_req = "R9";
    trip_a_at = 12;
    cfg(w0(2, 0, 2, 0), w1(1, 1, 0, 1, 1, 0, 0));
    run(150);
    cfg(w0(2, 0, 2, 0), w1(1, 1, 0, 1, 0, 1, 0));
    run(150);

    cur_req = "R10";
    cfg(w0(2, 0, 2, 0), w1(1, 1, 0, 0, 0, 1, 1));
    run(150);
    cfg(w0(2, 0, 2, 0), w1(1, 1, 0, 1, 0, 0, 1));
    run(150);
    cfg(w0(2, 0, 2, 0), w1(1, 1, 0, 0, 0, 1, 0));
    run(150);

    cur_req = "R11";
    wr(1'b1, w1(0, 1, 0, 1, 1, 1, 1));
    run(2);
    chk({oe_a, oe_b, out_a, out_b} == 4'b0000, "R11",
        $sformatf("disabled got %b%b%b%b exp 0000", oe_a, oe_b, out_a, out_b));
    run(20);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule